// File: doc/BRIEF.md
# Multithreaded Fetch Thread Selector

This block decides, each cycle, which hardware thread of a multithreaded core is allowed to fetch. It looks at a status code per thread, the occupancy of each thread's instruction queue and the occupancy of each thread's load/store queue. A static two-bit policy input selects how the winner is chosen. The result is a valid flag and a thread index, both purely combinational from the current inputs.

In the rotating policy the block holds an ordering of the threads. The first thread in that ordering that may fetch wins. When the consumer takes the grant, the winner moves to the back of the ordering. The two occupancy policies favour the thread whose back-end queue is least full. A fixed policy always names thread 0. When the block is built for one thread, that thread is named only when it may fetch, whatever the policy input says.

Top module: `fetch_thread_picker`

## Requirements
- R1: A thread is eligible only when its 3-bit status code is 0 (running), 1 (idle) or 6 (cache line returned). Codes 2 (squashing), 3 (blocked), 4 (waiting on cache response), 5 (waiting on cache retry) and 7 (parked) make it ineligible.
- R2: In the rotating and occupancy policies, if no thread is eligible, `selValid` is low.
- R3: With more than one thread configured and policy code 0 (fixed), `selValid` is high and `selThread` is 0, whatever the statuses.
- R4: With one thread configured, `selValid` equals that thread's eligibility and `selThread` is 0, for every policy code.
- R5: With policy code 1 (rotating), the grant goes to the first eligible thread in the priority ordering.
- R6: When a rotating grant is valid and `selAccept` is high at a rising clock edge, the granted thread is taken out of its position and placed last. All other threads keep their relative order, including ineligible ones.
- R7: The priority ordering does not change on an edge where `selAccept` is low, where `selValid` is low, or where the policy code is not 1.
- R8: After reset the priority ordering is thread 0, 1, 2 and so on, in ascending order.
- R9: With policy code 2 the eligible thread with the smallest instruction-queue count wins, and ties go to the lower index.
- R10: With policy code 3 the eligible thread with the smallest load/store-queue count wins, and ties go to the lower index.
- R11: The grant follows input changes in the same cycle, with no register between the inputs and `selValid`/`selThread`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| policyMode | input | 2 | 0 fixed, 1 rotating, 2 instruction-queue count, 3 load/store-queue count |
| threadStatus | input | NUM_THREADS*3 | Per-thread status code, thread i at bits [3i+2:3i] |
| iqCount | input | NUM_THREADS*CNT_W | Per-thread instruction-queue occupancy |
| lsqCount | input | NUM_THREADS*CNT_W | Per-thread load/store-queue occupancy |
| selAccept | input | 1 | Consumer takes the current grant this cycle |
| selValid | output | 1 | A thread is selected |
| selThread | output | TID_W | Index of the selected thread |

## Verification
The bench builds the main instance with four threads and a 4-bit occupancy width. With four threads the rotating ordering can reach deep permutations, and the narrow counts make occupancy ties frequent, so the lower-index tie rule is exercised often. A second instance with a single thread runs alongside on its own inputs. It covers the rule that one thread overrides every policy code, which no four-thread build can reach.

// File: rtl/picker_pkg.sv
package picker_pkg;

  localparam int STAT_W = 3;

  typedef enum logic [STAT_W-1:0] {
    ST_RUN       = 3'd0,
    ST_IDLE      = 3'd1,
    ST_SQUASH    = 3'd2,
    ST_BLOCK     = 3'd3,
    ST_WAIT_RESP = 3'd4,
    ST_WAIT_RTRY = 3'd5,
    ST_LINE_DONE = 3'd6,
    ST_PARKED    = 3'd7
  } thread_state_e;

  typedef enum logic [1:0] {
    POL_FIXED  = 2'd0,
    POL_ROTATE = 2'd1,
    POL_IQ     = 2'd2,
    POL_LSQ    = 2'd3
  } pick_policy_e;

  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic forceZero;
    logic rrMode;
    logic countMode;
    logic lsqSel;
    logic anyElig;
    logic rrCommit;
  } pick_strobe_t;

  function automatic logic stateEligible(input logic [STAT_W-1:0] code);
    return (code == ST_RUN) || (code == ST_IDLE) || (code == ST_LINE_DONE);
  endfunction

endpackage

// File: rtl/picker_ctrl.sv
module picker_ctrl
  import picker_pkg::*;
#(
  parameter int NUM_THREADS = 4
) (
  input  logic [1:0]                    policyMode,
  input  logic [NUM_THREADS*STAT_W-1:0] threadStatus,
  input  logic                          selAccept,
  output logic [NUM_THREADS-1:0]        eligVec,
  output pick_strobe_t                  strobes
);

  localparam bit MULTI = (NUM_THREADS > 1);

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_elig
    assign eligVec[t] = stateEligible(threadStatus[t*STAT_W +: STAT_W]);
  end

  always_comb begin
    strobes           = '0;
    strobes.anyElig   = |eligVec;
    strobes.forceZero = MULTI && (policyMode == POL_FIXED);
    strobes.rrMode    = MULTI && (policyMode == POL_ROTATE);
    strobes.countMode = MULTI && ((policyMode == POL_IQ) || (policyMode == POL_LSQ));
    strobes.lsqSel    = (policyMode == POL_LSQ);
    strobes.rrCommit  = strobes.rrMode && strobes.anyElig && selAccept;
  end

endmodule

// File: rtl/picker_datapath.sv
module picker_datapath
  import picker_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int CNT_W       = 6,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  pick_strobe_t                 strobes,
  input  logic [NUM_THREADS-1:0]       eligVec,
  input  logic [NUM_THREADS*CNT_W-1:0] iqCount,
  input  logic [NUM_THREADS*CNT_W-1:0] lsqCount,
  output logic                         selValid,
  output logic [TID_W-1:0]             selThread
);

  logic [TID_W-1:0] order     [NUM_THREADS];
  logic [TID_W-1:0] orderNext [NUM_THREADS];
  logic [NUM_THREADS*TID_W-1:0] orderFlat;

  logic             rrFound;
  logic [TID_W-1:0] rrPos;
  logic [TID_W-1:0] rrPick;

  logic             cntFound;
  logic [CNT_W-1:0] bestCnt;
  logic [TID_W-1:0] cntPick;

  // First eligible entry of the rotating ordering.
  always_comb begin
    rrFound = 1'b0;
    rrPos   = '0;
    rrPick  = '0;
    for (int p = 0; p < NUM_THREADS; p++) begin
      if (!rrFound && eligVec[order[p]]) begin
        rrFound = 1'b1;
        rrPos   = TID_W'(p);
        rrPick  = order[p];
      end
    end
  end

  // Move the winner to the tail, shift the entries behind it forward.
  always_comb begin
    for (int i = 0; i < NUM_THREADS; i++) begin
      int nxt;
      nxt = (i < NUM_THREADS - 1) ? i + 1 : i;
      if (TID_W'(i) < rrPos)
        orderNext[i] = order[i];
      else if (i == NUM_THREADS - 1)
        orderNext[i] = rrPick;
      else
        orderNext[i] = order[nxt];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_THREADS; i++) order[i] <= TID_W'(i);
    end else if (strobes.rrCommit) begin
      for (int i = 0; i < NUM_THREADS; i++) order[i] <= orderNext[i];
    end
  end

  // Smallest occupancy among eligible threads, lowest index on ties.
  always_comb begin
    cntFound = 1'b0;
    bestCnt  = '0;
    cntPick  = '0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      logic [CNT_W-1:0] c;
      c = strobes.lsqSel ? lsqCount[t*CNT_W +: CNT_W] : iqCount[t*CNT_W +: CNT_W];
      if (eligVec[t] && (!cntFound || c < bestCnt)) begin
        cntFound = 1'b1;
        bestCnt  = c;
        cntPick  = TID_W'(t);
      end
    end
  end

  always_comb begin
    selValid  = strobes.forceZero || strobes.anyElig;
    selThread = '0;
    if (strobes.forceZero)      selThread = '0;
    else if (strobes.rrMode)    selThread = rrPick;
    else if (strobes.countMode) selThread = cntPick;
  end

  // ---------------- assertions ----------------
  for (genvar i = 0; i < NUM_THREADS; i++) begin : g_flat
    assign orderFlat[i*TID_W +: TID_W] = order[i];
  end

  logic minOk;
  always_comb begin
    logic [CNT_W-1:0] sc;
    minOk = 1'b1;
    sc = strobes.lsqSel ? lsqCount[selThread*CNT_W +: CNT_W]
                        : iqCount[selThread*CNT_W +: CNT_W];
    for (int j = 0; j < NUM_THREADS; j++) begin
      logic [CNT_W-1:0] cj;
      cj = strobes.lsqSel ? lsqCount[j*CNT_W +: CNT_W] : iqCount[j*CNT_W +: CNT_W];
      if (eligVec[j] && ((cj < sc) || ((cj == sc) && (TID_W'(j) < selThread))))
        minOk = 1'b0;
    end
  end

  assert_grant_eligible_R1: assert property (@(posedge clk) disable iff (!rstN)
    (selValid && !strobes.forceZero) |-> eligVec[selThread]);

  assert_none_eligible_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.forceZero && (eligVec == '0)) |-> !selValid);

  assert_tail_on_accept_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rrCommit |=> (order[NUM_THREADS-1] == $past(selThread)));

  assert_order_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.rrCommit |=> $stable(orderFlat));

  assert_count_min_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.countMode && selValid) |-> minOk);

endmodule

// File: rtl/fetch_thread_picker.sv
module fetch_thread_picker
  import picker_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int CNT_W       = 6,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [1:0]                    policyMode,
  input  logic [NUM_THREADS*STAT_W-1:0] threadStatus,
  input  logic [NUM_THREADS*CNT_W-1:0]  iqCount,
  input  logic [NUM_THREADS*CNT_W-1:0]  lsqCount,
  input  logic                          selAccept,
  output logic                          selValid,
  output logic [TID_W-1:0]              selThread
);

  pick_strobe_t           strobes;
  logic [NUM_THREADS-1:0] eligVec;

  picker_ctrl #(.NUM_THREADS(NUM_THREADS)) u_ctrl (
    .policyMode  (policyMode),
    .threadStatus(threadStatus),
    .selAccept   (selAccept),
    .eligVec     (eligVec),
    .strobes     (strobes)
  );

  picker_datapath #(.NUM_THREADS(NUM_THREADS), .CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .eligVec  (eligVec),
    .iqCount  (iqCount),
    .lsqCount (lsqCount),
    .selValid (selValid),
    .selThread(selThread)
  );

  assert_fixed_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((NUM_THREADS > 1) && (policyMode == POL_FIXED)) |-> (selValid && (selThread == '0)));

  assert_single_thread_R4: assert property (@(posedge clk) disable iff (!rstN)
    (NUM_THREADS == 1) |-> ((selValid == stateEligible(threadStatus[STAT_W-1:0])) && (selThread == '0)));

endmodule

// File: tb/sim_fetch_thread_picker.sv
module sim_fetch_thread_picker;

  localparam int NT = 4;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [1:0]    policyMode = 2'd0;
  logic [NT*3-1:0]  threadStatus = '0;
  logic [NT*CW-1:0] iqCount = '0;
  logic [NT*CW-1:0] lsqCount = '0;
  logic          selAccept = 1'b0;
  logic          selValid;
  logic [1:0]    selThread;

  logic [2:0]    status1 = '0;
  logic [CW-1:0] iq1 = '0;
  logic [CW-1:0] lsq1 = '0;
  logic          accept1 = 1'b0;
  logic          valid1;
  logic [0:0]    thread1;

  always #2.5 clk = ~clk;

  fetch_thread_picker #(.NUM_THREADS(NT), .CNT_W(CW)) u0 (
    .clk(clk), .rstN(rstN), .policyMode(policyMode), .threadStatus(threadStatus),
    .iqCount(iqCount), .lsqCount(lsqCount), .selAccept(selAccept),
    .selValid(selValid), .selThread(selThread));

  fetch_thread_picker #(.NUM_THREADS(1), .CNT_W(CW)) u1 (
    .clk(clk), .rstN(rstN), .policyMode(policyMode), .threadStatus(status1),
    .iqCount(iq1), .lsqCount(lsq1), .selAccept(accept1),
    .selValid(valid1), .selThread(thread1));

  int nChk = 0;
  int nFail = 0;
  int mOrder [NT];

  function automatic bit elig(input logic [2:0] c);
    return (c == 3'd0) || (c == 3'd1) || (c == 3'd6);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic calcExp(output bit ev, output int et, output string req);
    ev = 0; et = 0; req = "R2";
    if (policyMode == 2'd0) begin
      ev = 1; et = 0; req = "R3";
    end else if (policyMode == 2'd1) begin
      for (int p = 0; p < NT; p++)
        if (!ev && elig(threadStatus[mOrder[p]*3 +: 3])) begin
          ev = 1; et = mOrder[p]; req = "R5";
        end
    end else begin
      int best;
      best = 0;
      for (int t = 0; t < NT; t++) begin
        int c;
        c = (policyMode == 2'd3) ? int'(lsqCount[t*CW +: CW]) : int'(iqCount[t*CW +: CW]);
        if (elig(threadStatus[t*3 +: 3]) && (!ev || c < best)) begin
          ev = 1; best = c; et = t;
          req = (policyMode == 2'd3) ? "R10" : "R9";
        end
      end
    end
  endtask

  // Drive at the falling edge, check 1 ns later, then update the model at the rising edge.
  task automatic step(input logic [1:0] pol, input logic [NT*3-1:0] st,
                      input logic [NT*CW-1:0] iqv, input logic [NT*CW-1:0] lsv,
                      input logic acc);
    bit ev; int et; string req;
    @(negedge clk);
    policyMode = pol; threadStatus = st; iqCount = iqv; lsqCount = lsv; selAccept = acc;
    status1 = 3'($urandom_range(0, 7)); accept1 = 1'($urandom_range(0, 1));
    #1;
    calcExp(ev, et, req);
    chk({req, "/R11 valid"}, int'(selValid), int'(ev));
    if (ev) chk({req, "/R6 thread"}, int'(selThread), et);
    chk("R4 valid single-thread build", int'(valid1), int'(elig(status1)));
    chk("R4 thread single-thread build", int'(thread1), 0);
    @(posedge clk);
    if (pol == 2'd1 && ev && acc) begin
      int pos;
      pos = 0;
      for (int p = 0; p < NT; p++) if (mOrder[p] == et) pos = p;
      for (int p = pos; p < NT - 1; p++) mOrder[p] = mOrder[p + 1];
      mOrder[NT - 1] = et;
    end
  endtask

  initial begin
    #400000;
    nChk++; nFail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NT; i++) mOrder[i] = i;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R8: reset ordering ascending, observed through accepted rotating grants.
    step(2'd1, 12'o0000, '0, '0, 1'b0);
    for (int k = 0; k < 5; k++) step(2'd1, 12'o0000, '0, '0, 1'b1);

    // R7: no accept keeps ordering.
    step(2'd1, 12'o1010, '0, '0, 1'b0);
    step(2'd1, 12'o1010, '0, '0, 1'b0);

    // R6: ineligible thread keeps its position while others pass.
    step(2'd1, {3'd0, 3'd0, 3'd0, 3'd3}, '0, '0, 1'b1);
    step(2'd1, {3'd0, 3'd0, 3'd0, 3'd3}, '0, '0, 1'b1);
    step(2'd1, 12'o0000, '0, '0, 1'b1);

    // R7: other policies leave ordering untouched.
    step(2'd2, 12'o0000, 16'h1234, '0, 1'b1);
    step(2'd1, 12'o0000, '0, '0, 1'b0);

    // R1 / R2: statuses 2,3,4,5,7 all ineligible.
    step(2'd1, {3'd2, 3'd3, 3'd4, 3'd5}, '0, '0, 1'b1);
    step(2'd2, {3'd7, 3'd5, 3'd4, 3'd3}, '0, '0, 1'b0);
    step(2'd3, {3'd2, 3'd7, 3'd5, 3'd4}, '0, '0, 1'b0);
    step(2'd1, {3'd6, 3'd2, 3'd1, 3'd7}, '0, '0, 1'b1);

    // R3: fixed policy with nothing eligible still names thread 0.
    step(2'd0, {3'd3, 3'd3, 3'd3, 3'd3}, '0, '0, 1'b1);

    // R9 / R10: ties to lower index, smallest count wins.
    step(2'd2, 12'o0000, 16'h5555, 16'h0000, 1'b0);
    step(2'd2, {3'd0, 3'd0, 3'd0, 3'd3}, 16'h3319, 16'h0000, 1'b0);
    step(2'd3, 12'o0000, 16'h0000, 16'h2F72, 1'b0);
    step(2'd3, {3'd6, 3'd1, 3'd0, 3'd0}, 16'h0000, 16'h1199, 1'b0);

    // Random mix.
    for (int n = 0; n < 3000; n++) begin
      logic [NT*3-1:0] st;
      for (int t = 0; t < NT; t++)
        st[t*3 +: 3] = ($urandom_range(0, 2) != 0) ? 3'($urandom_range(0, 1)) * 3'd6
                                                   : 3'($urandom_range(0, 7));
      step(2'($urandom_range(0, 3)), st, NT*CW'($urandom()), NT*CW'($urandom()),
           1'($urandom_range(0, 1)));
    end

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule